// File: doc/BRIEF.md
# Fetch Line Request Controller

This block sits in an instruction fetch stage that serves several hardware threads. Each thread keeps one buffered 64-byte instruction line. When fetch presents a program counter for a thread, the controller rounds it down to the start of its 64-byte line. It then reports a hit if that thread's buffered line is valid and covers the same line. On a miss it issues a line read on a ready/valid request port. The line then returns as eight 64-bit beats, and the controller writes them into the thread's buffer.

The memory side may refuse a request. A refused request is kept in one retry slot that all threads share. While that slot is occupied, no thread may start a new request, and the held request is sent again only when the memory side pulses its retry input. Each request carries a per-thread tag that is bumped on every new issue. A returning line whose tag no longer matches the thread's outstanding request, or that arrives while the thread is not waiting, is dropped and counted. A per-thread squash makes the thread forget its outstanding miss and releases the retry slot if that thread owns it.

Top module: `fetch_line_ctrl`

## Requirements
- R1: The request address is the fetch PC with bits [5:0] cleared. The hit comparison uses the same rounded address, so any two PCs inside one 64-byte line select the same line.
- R2: fetch_hit is high, and no new request is issued, when the fetched thread's line_valid is set and its stored line address equals the rounded fetch PC.
- R3: A miss on a thread that is idle, complete or stalled, while fetch_blocked is low, drives req_valid in the same cycle. The request carries the rounded address, the thread number and a tag equal to that thread's issue count modulo 16, where the first issue after reset has tag 1. If accepted, the thread's state becomes 1 (waiting for data) and its line_valid clears. State codes are 0 idle, 1 waiting for data, 2 waiting for retry, 3 fill complete, 4 filled but stalled.
- R4: A request refused (req_valid high, req_ready low) moves its thread to state 2 and sets fetch_blocked. While fetch_blocked is high, no thread issues a new request. At most one thread is in state 2 at a time.
- R5: While the retry slot is occupied, a pulse on retry drives req_valid with the stored address, thread and tag. If it is accepted, the thread moves to state 1 and fetch_blocked clears. If it is refused, everything stays as it was.
- R6: The line arrives as 8 beats of 64 bits, and beat k holds line bytes 8k to 8k+7, readable through line_rd_beat = k. A beat is accepted only for a thread in state 1 with a matching tag. The beat flagged last sets line_valid and moves the thread to state 4 if its stall_pending bit is high, otherwise to state 3.
- R7: A thread in state 4 moves to state 3 in the cycle after its stall_pending bit is low.
- R8: A beat for a thread that is not in state 1, or that carries another tag, is discarded, and the thread's state and line_valid are left unchanged. drop_count increases by one for every discarded beat flagged last.
- R9: A squash on a thread returns it to state 0, so that any data for its old request is dropped. The squash also suppresses any request from that thread in that cycle. If the thread owns the retry slot, the slot is emptied and fetch_blocked clears, and a later retry pulse drives no request.
- R10: After reset, every thread is in state 0 with line_valid low, fetch_blocked is low, drop_count is zero, and req_valid is low while no fetch is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetch lookup is presented this cycle |
| fetch_tid | input | 1 | Thread of the lookup |
| fetch_pc | input | 32 | Program counter of the lookup |
| stall_pending | input | 2 | Per-thread downstream stall |
| squash | input | 2 | Per-thread squash pulse |
| fetch_hit | output | 1 | Lookup hits the thread's buffered line |
| req_valid | output | 1 | Line read request valid |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | 32 | Line-aligned request address |
| req_tid | output | 1 | Thread of the request |
| req_tag | output | 4 | Per-thread request tag |
| retry | input | 1 | Memory asks for the held request again |
| rsp_valid | input | 1 | Response beat valid |
| rsp_tid | input | 1 | Thread of the response beat |
| rsp_tag | input | 4 | Tag of the response beat |
| rsp_data | input | 64 | Response beat data |
| rsp_last | input | 1 | Final beat of the line |
| line_rd_tid | input | 1 | Thread selected for line read-out |
| line_rd_beat | input | 3 | Beat selected for line read-out |
| line_rd_data | output | 64 | Selected 8 bytes of the buffered line |
| line_valid | output | 2 | Per-thread buffered line valid |
| thread_state | output | 6 | Per-thread 3-bit state code, thread t at [3t+2:3t] |
| fetch_blocked | output | 1 | Retry slot occupied; new requests held off |
| drop_count | output | 16 | Number of discarded line responses |

## Verification
The assertions assume that memory returns at most one beat per cycle and sends exactly eight beats per line, with the last of them flagged. They also assume that retry only arrives while the slot is occupied or is harmless otherwise, and that squash pulses last one cycle. The bench keeps to these assumptions: its memory model is a task that always sends a full eight-beat line in consecutive cycles, and it drives retry and squash for a single cycle each. Stale-tag and post-squash responses are still sent as full lines, so the drop counter sees a flagged last beat for every dropped line.

// File: rtl/flc_pkg.sv
// Shared types for the fetch line request controller.
package flc_pkg;
    typedef enum logic [2:0] {
        TS_IDLE       = 3'd0,
        TS_WAIT_RSP   = 3'd1,
        TS_WAIT_RETRY = 3'd2,
        TS_DONE       = 3'd3,
        TS_STALLED    = 3'd4
    } thr_state_e;
endpackage

// File: rtl/flc_thread_ctx.sv
// Per-thread miss context: state, stored line address, request tag,
// fill beat pointer and line-valid flag.
// Assumes issue and accepted beats for one thread never coincide
// (issue needs a non-waiting state, acceptance needs the waiting state).
module flc_thread_ctx
    import flc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    parameter int BCNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_ok,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              resend_ok,
    input  logic              squash,
    input  logic              stall,
    input  logic              rsp_here,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              rsp_last,
    output thr_state_e        state,
    output logic              line_valid,
    output logic [ADDR_W-1:0] line_addr,
    output logic [TAG_W-1:0]  tag,
    output logic [BCNT_W-1:0] beat,
    output logic              accept,
    output logic              drop_done
);

    // Beat acceptance: only while waiting and only for the live tag.
    always_comb begin
        accept    = rsp_here && !squash && (state == TS_WAIT_RSP) && (rsp_tag == tag);
        drop_done = rsp_here && rsp_last && !accept;
    end

    // Thread state machine with squash taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TS_IDLE;
            line_valid <= 1'b0;
            line_addr  <= '0;
            tag        <= '0;
            beat       <= '0;
        end else if (squash) begin
            state <= TS_IDLE;
            beat  <= '0;
        end else if (issue) begin
            state      <= issue_ok ? TS_WAIT_RSP : TS_WAIT_RETRY;
            tag        <= tag + 1'b1;
            line_addr  <= issue_addr;
            line_valid <= 1'b0;
            beat       <= '0;
        end else if (resend_ok) begin
            state <= TS_WAIT_RSP;
        end else if (accept) begin
            beat <= beat + 1'b1;
            if (rsp_last) begin
                line_valid <= 1'b1;
                state      <= stall ? TS_STALLED : TS_DONE;
            end
        end else if (state == TS_STALLED && !stall) begin
            state <= TS_DONE;
        end
    end

    // R6
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && rsp_last |=> line_valid && (state == TS_DONE || state == TS_STALLED));

    // R3
    wait_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == TS_WAIT_RSP |-> !line_valid);

endmodule

// File: rtl/flc_retry_slot.sv
// Single shared holding slot for a refused request plus the global
// blocked flag. Assumes a park only arrives while the slot is empty.
module flc_retry_slot #(
    parameter int NT     = 2,
    parameter int TID_W  = 1,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park,
    input  logic [TID_W-1:0]  park_tid,
    input  logic [ADDR_W-1:0] park_addr,
    input  logic [TAG_W-1:0]  park_tag,
    input  logic              retry,
    input  logic              resend_ok,
    input  logic [NT-1:0]     squash,
    output logic              full,
    output logic              blocked,
    output logic [TID_W-1:0]  slot_tid,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [TAG_W-1:0]  slot_tag
);

    // Slot fill, release on accepted resend, release on owner squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            blocked   <= 1'b0;
            slot_tid  <= '0;
            slot_addr <= '0;
            slot_tag  <= '0;
        end else if (park) begin
            full      <= 1'b1;
            blocked   <= 1'b1;
            slot_tid  <= park_tid;
            slot_addr <= park_addr;
            slot_tag  <= park_tag;
        end else if (full && squash[slot_tid]) begin
            full    <= 1'b0;
            blocked <= 1'b0;
        end else if (retry && full && resend_ok) begin
            full    <= 1'b0;
            blocked <= 1'b0;
        end else if (retry && !full) begin
            blocked <= 1'b0;
        end
    end

    // R4
    park_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park |-> !full);

endmodule

// File: rtl/flc_line_store.sv
// Per-thread line buffer written one beat at a time, read one beat at
// a time. Holds no reset: contents are qualified by line_valid.
module flc_line_store #(
    parameter int NT     = 2,
    parameter int TID_W  = 1,
    parameter int BEATS  = 8,
    parameter int BCNT_W = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [BCNT_W-1:0] wr_beat,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TID_W-1:0]  rd_tid,
    input  logic [BCNT_W-1:0] rd_beat,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = NT * BEATS;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    // Beat write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[IDX_W'({wr_tid, wr_beat})] <= wr_data;
    end

    // Asynchronous beat read.
    always_comb rd_data = mem[IDX_W'({rd_tid, rd_beat})];

endmodule

// File: rtl/fetch_line_ctrl.sv
// Fetch line request controller: line-aligned hit check, miss issue on a
// ready/valid port, single shared retry slot, tagged fills, squash.
// Assumes one response beat per cycle, 8 beats per line, last flagged.
module fetch_line_ctrl
    import flc_pkg::*;
#(
    parameter int NT         = 2,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int DATA_W     = 64,
    parameter int TAG_W      = 4,
    parameter int CNT_W      = 16,
    localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int BEATS     = LINE_BYTES * 8 / DATA_W,
    localparam int BCNT_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [TID_W-1:0]  fetch_tid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [NT-1:0]     stall_pending,
    input  logic [NT-1:0]     squash,
    output logic              fetch_hit,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [TID_W-1:0]  req_tid,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              retry,
    input  logic              rsp_valid,
    input  logic [TID_W-1:0]  rsp_tid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_last,
    input  logic [TID_W-1:0]  line_rd_tid,
    input  logic [BCNT_W-1:0] line_rd_beat,
    output logic [DATA_W-1:0] line_rd_data,
    output logic [NT-1:0]     line_valid,
    output logic [3*NT-1:0]   thread_state,
    output logic              fetch_blocked,
    output logic [CNT_W-1:0]  drop_count
);

    thr_state_e        st_v    [NT];
    logic [ADDR_W-1:0] laddr_v [NT];
    logic [TAG_W-1:0]  tag_v   [NT];
    logic [BCNT_W-1:0] beat_v  [NT];
    logic [NT-1:0]     accept_v, drop_v, wait_retry_v;

    logic [ADDR_W-1:0] aligned_pc;
    logic              busy, new_issue, resend, park, slot_full;
    logic [TID_W-1:0]  slot_tid;
    logic [ADDR_W-1:0] slot_addr;
    logic [TAG_W-1:0]  slot_tag;

    // Line alignment, hit check and issue decision.
    always_comb begin
        aligned_pc = {fetch_pc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        fetch_hit  = fetch_valid && line_valid[fetch_tid] && (laddr_v[fetch_tid] == aligned_pc);
        busy       = (st_v[fetch_tid] == TS_WAIT_RSP) || (st_v[fetch_tid] == TS_WAIT_RETRY);
        new_issue  = fetch_valid && !fetch_hit && !fetch_blocked && !busy && !squash[fetch_tid];
        resend     = retry && slot_full && !squash[slot_tid];
        park       = new_issue && !req_ready;
    end

    // Request port mux: the held request or a new miss.
    always_comb begin
        req_valid = new_issue || resend;
        req_addr  = resend ? slot_addr : aligned_pc;
        req_tid   = resend ? slot_tid  : fetch_tid;
        req_tag   = resend ? slot_tag  : tag_v[fetch_tid] + 1'b1;
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        flc_thread_ctx #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .BCNT_W(BCNT_W)) ctx_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue      (new_issue && fetch_tid == TID_W'(t)),
            .issue_ok   (req_ready),
            .issue_addr (aligned_pc),
            .resend_ok  (resend && req_ready && slot_tid == TID_W'(t)),
            .squash     (squash[t]),
            .stall      (stall_pending[t]),
            .rsp_here   (rsp_valid && rsp_tid == TID_W'(t)),
            .rsp_tag    (rsp_tag),
            .rsp_last   (rsp_last),
            .state      (st_v[t]),
            .line_valid (line_valid[t]),
            .line_addr  (laddr_v[t]),
            .tag        (tag_v[t]),
            .beat       (beat_v[t]),
            .accept     (accept_v[t]),
            .drop_done  (drop_v[t])
        );
        assign thread_state[3*t +: 3] = st_v[t];
        assign wait_retry_v[t]        = (st_v[t] == TS_WAIT_RETRY);
    end

    flc_retry_slot #(.NT(NT), .TID_W(TID_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .park      (park),
        .park_tid  (fetch_tid),
        .park_addr (aligned_pc),
        .park_tag  (req_tag),
        .retry     (retry),
        .resend_ok (resend && req_ready),
        .squash    (squash),
        .full      (slot_full),
        .blocked   (fetch_blocked),
        .slot_tid  (slot_tid),
        .slot_addr (slot_addr),
        .slot_tag  (slot_tag)
    );

    flc_line_store #(.NT(NT), .TID_W(TID_W), .BEATS(BEATS), .BCNT_W(BCNT_W), .DATA_W(DATA_W)) store_i (
        .clk     (clk),
        .wr_en   (|accept_v),
        .wr_tid  (rsp_tid),
        .wr_beat (beat_v[rsp_tid]),
        .wr_data (rsp_data),
        .rd_tid  (line_rd_tid),
        .rd_beat (line_rd_beat),
        .rd_data (line_rd_data)
    );

    // Count discarded line responses.
    always_ff @(posedge clk) begin
        if (!rst_n)       drop_count <= '0;
        else if (|drop_v) drop_count <= drop_count + 1'b1;
    end

    // R4
    reject_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> fetch_blocked);

    // R4
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_blocked && !retry |-> !req_valid);

    // R4
    one_retry_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wait_retry_v));

    // R2
    hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit && !fetch_blocked |-> !req_valid);

    // R8
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count == $past(drop_count) || drop_count == CNT_W'($past(drop_count) + 1'b1));

endmodule

// File: tb/fetch_line_ctrl_tb.sv
`timescale 1ns/1ps
module fetch_line_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_tid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [1:0]  stall_pending = '0;
    logic [1:0]  squash = '0;
    logic        fetch_hit;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr;
    logic        req_tid;
    logic [3:0]  req_tag;
    logic        retry = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_tid = 1'b0;
    logic [3:0]  rsp_tag = '0;
    logic [63:0] rsp_data = '0;
    logic        rsp_last = 1'b0;
    logic        line_rd_tid = 1'b0;
    logic [2:0]  line_rd_beat = '0;
    logic [63:0] line_rd_data;
    logic [1:0]  line_valid;
    logic [5:0]  thread_state;
    logic        fetch_blocked;
    logic [15:0] drop_count;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fetch_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_tid(fetch_tid),
        .fetch_pc(fetch_pc), .stall_pending(stall_pending), .squash(squash),
        .fetch_hit(fetch_hit), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tid(req_tid), .req_tag(req_tag), .retry(retry),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .line_rd_tid(line_rd_tid), .line_rd_beat(line_rd_beat),
        .line_rd_data(line_rd_data), .line_valid(line_valid), .thread_state(thread_state),
        .fetch_blocked(fetch_blocked), .drop_count(drop_count)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] pat(input logic [31:0] a, input int k);
        return {a, 29'd0, 3'(k)};
    endfunction

    function automatic logic [2:0] st(input int t);
        return thread_state[3*t +: 3];
    endfunction

    task automatic send_line(input logic tid, input logic [3:0] tag, input logic [31:0] a);
        for (int k = 0; k < 8; k++) begin
            rsp_valid = 1'b1; rsp_tid = tid; rsp_tag = tag;
            rsp_data = pat(a, k); rsp_last = (k == 7);
            step();
        end
        rsp_valid = 1'b0; rsp_last = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R10", "state0", 64'(st(0)), 0);
        chk("R10", "state1", 64'(st(1)), 0);
        chk("R10", "line_valid", 64'(line_valid), 0);
        chk("R10", "blocked", 64'(fetch_blocked), 0);
        chk("R10", "drops", 64'(drop_count), 0);
        chk("R10", "req_valid", 64'(req_valid), 0);
    endtask

    task automatic t_miss_fill();
        fetch_valid = 1'b1; fetch_tid = 1'b0; fetch_pc = 32'h1234; req_ready = 1'b1;
        #1;
        chk("R1", "req_addr", 64'(req_addr), 64'h1200);
        chk("R3", "req_valid", 64'(req_valid), 1);
        chk("R3", "req_tag", 64'(req_tag), 1);
        chk("R3", "req_tid", 64'(req_tid), 0);
        step();
        fetch_valid = 1'b0;
        chk("R3", "state0 waiting", 64'(st(0)), 1);
        chk("R3", "line_valid0", 64'(line_valid[0]), 0);
        send_line(1'b0, 4'd1, 32'h1200);
        chk("R6", "state0 done", 64'(st(0)), 3);
        chk("R6", "line_valid0", 64'(line_valid[0]), 1);
        line_rd_tid = 1'b0; line_rd_beat = 3'd5; #1;
        chk("R6", "beat5", line_rd_data, pat(32'h1200, 5));
    endtask

    task automatic t_hit_stall();
        fetch_valid = 1'b1; fetch_tid = 1'b0; fetch_pc = 32'h123C;
        #1;
        chk("R2", "hit", 64'(fetch_hit), 1);
        chk("R2", "no req", 64'(req_valid), 0);
        fetch_pc = 32'h1240;
        #1;
        chk("R1", "next line miss", 64'(fetch_hit), 0);
        chk("R1", "req_addr", 64'(req_addr), 64'h1240);
        chk("R3", "tag2", 64'(req_tag), 2);
        step();
        fetch_valid = 1'b0; stall_pending = 2'b01;
        send_line(1'b0, 4'd2, 32'h1240);
        chk("R6", "stalled fill", 64'(st(0)), 4);
        stall_pending = 2'b00;
        step();
        chk("R7", "stall release", 64'(st(0)), 3);
    endtask

    task automatic t_retry();
        req_ready = 1'b0; fetch_valid = 1'b1; fetch_tid = 1'b1; fetch_pc = 32'h8010;
        #1;
        chk("R3", "t1 tag1", 64'(req_tag), 1);
        step();
        chk("R4", "state1 retry", 64'(st(1)), 2);
        chk("R4", "blocked", 64'(fetch_blocked), 1);
        req_ready = 1'b1; fetch_tid = 1'b0; fetch_pc = 32'h9000;
        #1;
        chk("R4", "other thread held", 64'(req_valid), 0);
        step();
        chk("R4", "state0 unchanged", 64'(st(0)), 3);
        fetch_valid = 1'b0; retry = 1'b1; req_ready = 1'b0;
        #1;
        chk("R5", "resend valid", 64'(req_valid), 1);
        chk("R5", "resend addr", 64'(req_addr), 64'h8000);
        chk("R5", "resend tid", 64'(req_tid), 1);
        chk("R5", "resend tag", 64'(req_tag), 1);
        step();
        chk("R5", "refused resend keeps", 64'(st(1)), 2);
        req_ready = 1'b1;
        step();
        retry = 1'b0;
        chk("R5", "state1 waiting", 64'(st(1)), 1);
        chk("R5", "unblocked", 64'(fetch_blocked), 0);
    endtask

    task automatic t_stale();
        send_line(1'b1, 4'd5, 32'h8000);
        chk("R8", "drop count", 64'(drop_count), 1);
        chk("R8", "state1 kept", 64'(st(1)), 1);
        chk("R8", "line_valid1 kept", 64'(line_valid[1]), 0);
        send_line(1'b1, 4'd1, 32'h8000);
        chk("R6", "t1 done", 64'(st(1)), 3);
        line_rd_tid = 1'b1; line_rd_beat = 3'd0; #1;
        chk("R6", "t1 beat0", line_rd_data, pat(32'h8000, 0));
    endtask

    task automatic t_squash_miss();
        fetch_valid = 1'b1; fetch_tid = 1'b0; fetch_pc = 32'h5004; req_ready = 1'b1;
        #1;
        chk("R3", "tag3", 64'(req_tag), 3);
        step();
        fetch_valid = 1'b0; squash = 2'b01;
        step();
        squash = 2'b00;
        chk("R9", "state0 idle", 64'(st(0)), 0);
        send_line(1'b0, 4'd3, 32'h5000);
        chk("R8", "post squash drop", 64'(drop_count), 2);
        chk("R9", "line_valid0 low", 64'(line_valid[0]), 0);
    endtask

    task automatic t_squash_slot();
        req_ready = 1'b0; fetch_valid = 1'b1; fetch_tid = 1'b1; fetch_pc = 32'hA000;
        step();
        fetch_valid = 1'b0;
        chk("R4", "blocked again", 64'(fetch_blocked), 1);
        squash = 2'b10;
        step();
        squash = 2'b00;
        chk("R9", "slot freed", 64'(fetch_blocked), 0);
        chk("R9", "state1 idle", 64'(st(1)), 0);
        retry = 1'b1;
        #1;
        chk("R9", "no resend", 64'(req_valid), 0);
        step();
        retry = 1'b0; req_ready = 1'b1;
        fetch_valid = 1'b1; fetch_tid = 1'b0; fetch_pc = 32'hB000;
        #1;
        chk("R9", "issue resumes", 64'(req_valid), 1);
        step();
        fetch_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        rst_n = 1'b1;
        t_reset();
        t_miss_fill();
        t_hit_stall();
        t_retry();
        t_stale();
        t_squash_miss();
        t_squash_slot();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule